// File: doc/BRIEF.md
# Daisy-Chained Bus Ownership Agents

This block settles which of several devices on a shared bus becomes the bus master, without any central arbiter. Every device carries an identical agent. The agents share three signals. The first is a request line: the OR of every device's request. The second is a busy line: the OR of every agent's holding flag. The third is a priority token that runs from agent to agent along a chain. The head of the chain has its token input tied high, so position in the chain sets the priority.

While the busy line is low, a requesting agent cuts the token to every agent after it. An agent that is requesting and still sees the token arriving takes ownership on the next clock edge. From that edge it shows a grant to its client and holds the busy line. It keeps the bus until its client raises done. It then drops grant and busy and lets the token pass again. A model level connects the agents in a chain with generate loops. It replaces open-drain wiring with AND/OR reduction, so that the whole arbitration can be checked at one set of ports.

Top module: `chain_arb_bus`

## Requirements
- R1: Reset is synchronous and active low. After reset no `grant_o` bit is set, `bus_busy_o` is 0 and `bus_req_o` is 0 while no request is present.
- R2: `bus_req_o` is the OR of all `dev_req_i` bits in the same cycle.
- R3: The bus is idle when `bus_busy_o` is 0. At a clock edge where the bus is idle and at least one device requests, the requesting device with the lowest index (index 0 is the head of the chain) gets its `grant_o` bit set after that edge.
- R4: At most one `grant_o` bit is ever set.
- R5: `bus_busy_o` is 1 exactly when some `grant_o` bit is 1.
- R6: While the bus is busy, new requests do not change `grant_o`, even when they come from a device higher in the chain. Only the owner's done changes it.
- R7: When the owner's `dev_done_i` bit is 1 at a clock edge, its grant and `bus_busy_o` are 0 after that edge. Arbitration among pending requests then takes place at the following edge.
- R8: A `dev_done_i` bit from a device that does not own the bus has no effect.
- R9: The owner keeps its grant when its request drops, until its done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req_i | input | N_DEV | Request from each device, bit 0 at the chain head |
| dev_done_i | input | N_DEV | End-of-tenure strobe from each device |
| grant_o | output | N_DEV | Ownership indication for each device |
| bus_busy_o | output | 1 | Shared busy line (OR of holders) |
| bus_req_o | output | 1 | Shared request line (OR of requests) |

## Verification
Suppose an agent's ownership state were corrupted. That would appear at the ports within one clock edge, in one of three ways: two grant bits set together, a grant that changes while the bus is busy, or a grant that survives its own done. A token that propagates wrongly along the chain would show up as the wrong index winning at the edge after an idle-bus request. If the release went wrong, the hand-over to the next requester would come late or never, one edge after the idle cycle that should follow done.

// File: rtl/chain_arb_pkg.sv
// Package: shared types for the chain arbitration agents.
// Assumes nothing beyond a two-state ownership model per agent.
package chain_arb_pkg;
    typedef enum logic [0:0] {
        AG_IDLE  = 1'b0,
        AG_OWNER = 1'b1
    } agent_state_t;
endpackage

// File: rtl/or_reduce.sv
// Module: or_reduce
// Models one wired-OR bus line as an OR reduction over its drivers.
// Assumes every driver is active high.
module or_reduce #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] drv_i,
    output logic             line_o
);
    // Reduce all drivers onto the shared line.
    always_comb begin
        line_o = |drv_i;
    end
endmodule

// File: rtl/chain_agent.sv
// Module: chain_agent
// One arbitration agent. It takes the bus when it requests while the bus is
// idle and the priority token reaches it, holds busy until done, and cuts
// the token to the agents after it while it requests or owns the bus.
// Assumes bus_busy_i is the OR of all agents' busy_o and is fed back combinationally.
module chain_agent
    import chain_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic done_i,
    input  logic tok_in_i,
    input  logic bus_busy_i,
    output logic tok_out_o,
    output logic grant_o,
    output logic busy_o
);
    agent_state_t state_q;
    logic         contend;
    logic         win;

    // The agent contends when idle, requesting and the bus is free.
    always_comb begin
        contend = (state_q == AG_IDLE) && req_i && !bus_busy_i;
        win     = contend && tok_in_i;
    end

    // Token passes only through agents that neither contend nor own.
    always_comb begin
        tok_out_o = tok_in_i && !contend && (state_q == AG_IDLE);
    end

    // Ownership state: taken on a win, given up on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AG_IDLE;
        end else if (state_q == AG_IDLE) begin
            if (win) state_q <= AG_OWNER;
        end else if (done_i) begin
            state_q <= AG_IDLE;
        end
    end

    // Grant and busy both follow ownership.
    always_comb begin
        grant_o = (state_q == AG_OWNER);
        busy_o  = (state_q == AG_OWNER);
    end

    // R3: a winning agent holds the grant after the edge.
    a_r3_win_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && tok_in_i && !bus_busy_i && !grant_o) |=> grant_o);
    // R7: the owner's done releases the grant at the next edge.
    a_r7_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && done_i) |=> !grant_o);
    // R9: without done the owner keeps the bus.
    a_r9_owner_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !done_i) |=> grant_o);
endmodule

// File: rtl/chain_arb_bus.sv
// Module: chain_arb_bus
// Model level: N_DEV agents in a priority chain, with the request and busy
// lines built as OR reductions. Index 0 is the head, its token input tied high.
// Assumes each device lowers its request when it raises done.
module chain_arb_bus #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_req_i,
    input  logic [N_DEV-1:0] dev_done_i,
    output logic [N_DEV-1:0] grant_o,
    output logic             bus_busy_o,
    output logic             bus_req_o
);
    localparam int N_LINK = N_DEV + 1;

    logic [N_LINK-1:0] tok;
    logic [N_DEV-1:0]  busy_drv;

    // The chain head always holds the token.
    always_comb begin
        tok[0] = 1'b1;
    end

    // Shared request line.
    or_reduce #(.WIDTH(N_DEV)) u_req_line (
        .drv_i  (dev_req_i),
        .line_o (bus_req_o)
    );

    // Shared busy line.
    or_reduce #(.WIDTH(N_DEV)) u_busy_line (
        .drv_i  (busy_drv),
        .line_o (bus_busy_o)
    );

    // One agent per device, token threaded from each to the next.
    for (genvar g = 0; g < N_DEV; g++) begin : g_agent
        chain_agent u_agent (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (dev_req_i[g]),
            .done_i     (dev_done_i[g]),
            .tok_in_i   (tok[g]),
            .bus_busy_i (bus_busy_o),
            .tok_out_o  (tok[g+1]),
            .grant_o    (grant_o[g]),
            .busy_o     (busy_drv[g])
        );
    end

    // R4: never more than one owner.
    a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    // R5: the busy line matches the presence of a grant.
    a_r5_busy_matches: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy_o == (grant_o != '0));
    // R6/R8: while busy, grants move only on the owner's done.
    a_r6_grant_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy_o && ((grant_o & dev_done_i) == '0)) |=> $stable(grant_o));
endmodule

// File: tb/chain_arb_bus_tb_top.sv
// Directed bench for chain_arb_bus: one task per scenario, each checking itself.
module chain_arb_bus_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] grant;
    logic         busy;
    logic         breq;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    chain_arb_bus #(.N_DEV(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_req_i  (req),
        .dev_done_i (done),
        .grant_o    (grant),
        .bus_busy_o (busy),
        .bus_req_o  (breq)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_grant(input logic [N-1:0] exp, input string tag);
        chk(grant == exp, tag, 32'(grant), 32'(exp));
        chk(busy == (exp != '0), {tag, " busy (R5)"}, 32'(busy), 32'(exp != '0));
    endtask

    // R4: single owner monitored every cycle.
    always @(negedge clk) begin
        if (rst_n && !ended) chk($onehot0(grant), "R4 onehot grant", 32'(grant), 32'(0));
    end

    task automatic release_dev(input int idx);
        done[idx] = 1'b1;
        req[idx]  = 1'b0;
        @(negedge clk);
        expect_grant('0, "R7 release");
        done = '0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        expect_grant('0, "R1 reset grant");
        chk(breq == 1'b0, "R1 reset req line", 32'(breq), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
        expect_grant('0, "R1 after reset");
    endtask

    task automatic t_single();
        req[2] = 1'b1;
        #1 chk(breq == 1'b1, "R2 req line", 32'(breq), 32'(1));
        @(negedge clk);
        expect_grant(4'b0100, "R3 single requester");
        release_dev(2);
    endtask

    task automatic t_priority();
        req = 4'b1010;
        @(negedge clk);
        expect_grant(4'b0010, "R3 lowest index wins");
        release_dev(1);
        @(negedge clk);
        expect_grant(4'b1000, "R7 handover after idle");
        release_dev(3);
    endtask

    task automatic t_block();
        req[3] = 1'b1;
        @(negedge clk);
        expect_grant(4'b1000, "R3 tail wins alone");
        req[0] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            expect_grant(4'b1000, "R6 busy blocks head");
        end
        release_dev(3);
        @(negedge clk);
        expect_grant(4'b0001, "R7 head wins after release");
        release_dev(0);
    endtask

    task automatic t_foreign_done();
        req[1] = 1'b1;
        @(negedge clk);
        expect_grant(4'b0010, "R3 grant dev1");
        done = 4'b0101;
        @(negedge clk);
        expect_grant(4'b0010, "R8 foreign done ignored");
        done = '0;
        @(negedge clk);
        expect_grant(4'b0010, "R8 still owner");
        release_dev(1);
    endtask

    task automatic t_hold();
        req[2] = 1'b1;
        @(negedge clk);
        expect_grant(4'b0100, "R3 grant dev2");
        req[2] = 1'b0;
        #1 chk(breq == 1'b0, "R2 req line low", 32'(breq), 32'(0));
        repeat (2) @(negedge clk);
        expect_grant(4'b0100, "R9 hold without request");
        release_dev(2);
        @(negedge clk);
        expect_grant('0, "R3 no request no grant");
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_priority();
        t_block();
        t_foreign_done();
        t_hold();
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule